// File: doc/BRIEF.md
# Serial Port Register Block with Internal Loopback

This block is a byte-wide serial port controller with a small register window. Its transmitter serializes one character at a time from a single holding register, and its receiver rebuilds characters into a single receive buffer. Each character is sent as a start bit, eight data bits with the least significant bit first, an optional parity bit and one stop bit. Every bit lasts `CLKS_PER_BIT` clock cycles. Software reaches the registers through a three-bit address, together with a write strobe and a read strobe. Reads return data combinationally. A read strobe at the clock edge applies the side effects of that read.

A mode bit routes the transmitter straight into the receiver. While this bit is set, the external line is held at the idle level. This lets a driver test the full send and receive path, the status flags and the interrupt logic without any wiring outside the block. Three interrupt causes are merged onto one interrupt output: receive errors, received data ready, and holding register empty. An identification register reports the highest-priority cause that is pending and enabled.

Top module: `uart_loop`

## Requirements
- R1: After reset the status register reads 0x60, the identification register reads 0x01, the enable register reads 0x00, `irq` is low and `serial_out` is high.
- R2: The register offsets are as follows. Offset 0 is the receive buffer on reads and the transmit holding register on writes. Offset 1 is the interrupt enable register, offset 2 is the identification register, offset 3 is line control and offset 4 is mode control. Offset 5 is the status register and offset 7 is a free read/write scratch byte. Line control and mode control read back the value last written.
- R3: A transmitted frame consists of a low start bit, eight data bits with the least significant bit first, a parity bit when line control bit 3 is set, and a high stop bit. The parity is odd when line control bit 4 is clear and even when it is set, so the value 0x0B selects odd parity. Each bit lasts `CLKS_PER_BIT` cycles.
- R4: When mode control bit 4 is set, the transmitter feeds the receiver and `serial_out` stays high. When the bit is clear, transmitted characters are not received and no receive interrupt follows.
- R5: The status register bits are: bit 0 data ready, bit 1 overrun, bit 2 parity error, bit 3 framing error, bit 5 holding register empty and bit 6 transmitter fully idle. After a looped-back character has arrived and the transmitter has gone idle, the register reads 0x61.
- R6: A read at offset 0 returns the last received byte and clears data ready. A read made before any new byte arrives does not hide or corrupt the next received character or its interrupt.
- R7: The enable register uses bit 0 for received data, bit 1 for holding register empty and bit 2 for receive errors. The identification register reads 0x06 for errors, 0x04 for data ready and 0x02 for holding register empty, in that order of priority, and 0x01 when nothing is pending. `irq` is high whenever the identification register does not read 0x01.
- R8: The holding-empty interrupt is raised in two cases: when the holding register hands its byte to the shifter, or when the interrupt is enabled while the holding register is already empty. It is never raised while a byte is still waiting in the holding register. A write to offset 0, or a read of the identification register while it reports 0x02, clears the interrupt.
- R9: If a character completes while data ready is still set, the overrun bit is set and the receive buffer keeps the newer byte.
- R10: A status register read clears the overrun, parity error and framing error bits.
- R11: A received parity bit that does not match the configured parity sets the parity error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (side effects at the clock edge) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational from `reg_addr`) |
| serial_in | input | 1 | External receive line |
| serial_out | output | 1 | External transmit line |
| irq | output | 1 | Interrupt request |

## Verification
A stuck holding-full flag shows up within one character time. In that case the empty bit never rises in the status register, and the holding-empty interrupt either fires while a byte is still waiting or never fires at all. A corrupted receive path is visible at the ports once the looped character completes: the received byte, the 0x61 status value or the 0x04 identification code comes out wrong. An error flag left uncleared shows up on the very next status read, and a wrong priority order shows up on the very next identification read. Overrun and parity faults are forced deliberately, and each is judged from the status value and identification value read immediately afterwards.

// File: rtl/uart_loop_pkg.sv
package uart_loop_pkg;

    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_IER  = 3'd1;
    localparam logic [2:0] OFS_IID  = 3'd2;
    localparam logic [2:0] OFS_LCR  = 3'd3;
    localparam logic [2:0] OFS_MCR  = 3'd4;
    localparam logic [2:0] OFS_LSR  = 3'd5;
    localparam logic [2:0] OFS_SCR  = 3'd7;

    typedef enum logic [7:0] {
        ID_NONE = 8'h01,
        ID_THRE = 8'h02,
        ID_RDA  = 8'h04,
        ID_LINE = 8'h06
    } int_id_e;

    typedef struct packed {
        logic par_en;
        logic par_even;
    } frame_cfg_t;

    typedef struct packed {
        logic [7:0] data;
        logic       par_err;
        logic       frm_err;
    } rx_char_t;

    function automatic logic parity_of(input logic [7:0] d, input logic even);
        return even ? (^d) : ~(^d);
    endfunction

endpackage

// File: rtl/uart_loop_tx.sv
module uart_loop_tx
    import uart_loop_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] din,
    input  frame_cfg_t cfg,
    output logic       busy,
    output logic       line
);
    localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam int FW = 11;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

    logic [FW-1:0] shreg;
    logic [CW-1:0] cnt;
    logic [3:0]    left;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            shreg <= '1;
            cnt   <= '0;
            left  <= '0;
        end else if (!busy && load) begin
            shreg <= {1'b1, cfg.par_en ? parity_of(din, cfg.par_even) : 1'b1, din, 1'b0};
            left  <= cfg.par_en ? 4'd11 : 4'd10;
            cnt   <= '0;
            busy  <= 1'b1;
        end else if (busy) begin
            if (cnt == LAST) begin
                cnt   <= '0;
                shreg <= {1'b1, shreg[FW-1:1]};
                left  <= left - 4'd1;
                if (left == 4'd1) busy <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign line = busy ? shreg[0] : 1'b1;

endmodule

// File: rtl/uart_loop_rx.sv
module uart_loop_rx
    import uart_loop_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line,
    input  frame_cfg_t cfg,
    output logic       done,
    output rx_char_t   ch
);
    localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);
    localparam logic [CW-1:0] MID  = CW'((CLKS_PER_BIT / 2) - 1);

    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_state_e;

    rx_state_e  st;
    logic [1:0] sync;
    logic       s;
    logic [CW-1:0] cnt;
    logic [2:0] idx;
    logic [7:0] shreg;
    logic       perr;

    assign s = sync[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync  <= 2'b11;
            st    <= RX_IDLE;
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
            perr  <= 1'b0;
            done  <= 1'b0;
            ch    <= '0;
        end else begin
            sync <= {sync[0], line};
            done <= 1'b0;
            unique case (st)
                RX_IDLE: begin
                    cnt <= '0;
                    if (!s) st <= RX_START;
                end
                RX_START: begin
                    if (cnt == MID) begin
                        cnt  <= '0;
                        idx  <= '0;
                        perr <= 1'b0;
                        st   <= s ? RX_IDLE : RX_DATA;
                    end else cnt <= cnt + 1'b1;
                end
                RX_DATA: begin
                    if (cnt == LAST) begin
                        cnt   <= '0;
                        shreg <= {s, shreg[7:1]};
                        idx   <= idx + 3'd1;
                        if (idx == 3'd7) st <= cfg.par_en ? RX_PAR : RX_STOP;
                    end else cnt <= cnt + 1'b1;
                end
                RX_PAR: begin
                    if (cnt == LAST) begin
                        cnt  <= '0;
                        perr <= (s != parity_of(shreg, cfg.par_even));
                        st   <= RX_STOP;
                    end else cnt <= cnt + 1'b1;
                end
                RX_STOP: begin
                    if (cnt == LAST) begin
                        cnt  <= '0;
                        done <= 1'b1;
                        ch   <= '{data: shreg, par_err: perr, frm_err: !s};
                        st   <= RX_IDLE;
                    end else cnt <= cnt + 1'b1;
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/uart_loop.sv
module uart_loop
    import uart_loop_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       serial_in,
    output logic       serial_out,
    output logic       irq
);
    logic [2:0] ier;
    logic [7:0] lcr, mcr, scr, thr, rbr;
    logic       thr_full, thre_pend;
    logic       dr_q, oe_q, pe_q, fe_q;
    logic       tx_busy, tx_line, tx_start, loop_on, rx_line, rx_done;
    rx_char_t   rx_ch;
    frame_cfg_t cfg;
    int_id_e    iid;
    logic [7:0] lsr;

    assign cfg      = '{par_en: lcr[3], par_even: lcr[4]};
    assign loop_on  = mcr[4];
    assign tx_start = thr_full && !tx_busy;
    assign rx_line  = loop_on ? tx_line : serial_in;
    assign serial_out = loop_on ? 1'b1 : tx_line;

    uart_loop_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
        .clk(clk), .rst(rst), .load(tx_start), .din(thr), .cfg(cfg),
        .busy(tx_busy), .line(tx_line)
    );

    uart_loop_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
        .clk(clk), .rst(rst), .line(rx_line), .cfg(cfg),
        .done(rx_done), .ch(rx_ch)
    );

    assign lsr = {1'b0, !thr_full && !tx_busy, !thr_full, 1'b0, fe_q, pe_q, oe_q, dr_q};

    always_comb begin
        if (ier[2] && (oe_q || pe_q || fe_q)) iid = ID_LINE;
        else if (ier[0] && dr_q)              iid = ID_RDA;
        else if (ier[1] && thre_pend)         iid = ID_THRE;
        else                                  iid = ID_NONE;
    end

    assign irq = (iid != ID_NONE);

    always_comb begin
        unique case (reg_addr)
            OFS_DATA: reg_rdata = rbr;
            OFS_IER:  reg_rdata = {5'd0, ier};
            OFS_IID:  reg_rdata = iid;
            OFS_LCR:  reg_rdata = lcr;
            OFS_MCR:  reg_rdata = mcr;
            OFS_LSR:  reg_rdata = lsr;
            OFS_SCR:  reg_rdata = scr;
            default:  reg_rdata = 8'h00;
        endcase
    end

    logic wr_data, wr_ier, rd_data, rd_lsr, rd_iid;
    assign wr_data = reg_wr && (reg_addr == OFS_DATA);
    assign wr_ier  = reg_wr && (reg_addr == OFS_IER);
    assign rd_data = reg_rd && (reg_addr == OFS_DATA);
    assign rd_lsr  = reg_rd && (reg_addr == OFS_LSR);
    assign rd_iid  = reg_rd && (reg_addr == OFS_IID);

    always_ff @(posedge clk) begin
        if (rst) begin
            ier <= '0; lcr <= '0; mcr <= '0; scr <= '0;
            thr <= '0; rbr <= '0;
            thr_full <= 1'b0; thre_pend <= 1'b0;
            dr_q <= 1'b0; oe_q <= 1'b0; pe_q <= 1'b0; fe_q <= 1'b0;
        end else begin
            if (wr_ier) ier <= reg_wdata[2:0];
            if (reg_wr && reg_addr == OFS_LCR) lcr <= reg_wdata;
            if (reg_wr && reg_addr == OFS_MCR) mcr <= reg_wdata;
            if (reg_wr && reg_addr == OFS_SCR) scr <= reg_wdata;
            if (wr_data) thr <= reg_wdata;

            if (wr_data)       thr_full <= 1'b1;
            else if (tx_start) thr_full <= 1'b0;

            if (wr_data)       thre_pend <= 1'b0;
            else if (tx_start) thre_pend <= 1'b1;
            else if (wr_ier && reg_wdata[1] && !ier[1] && !thr_full) thre_pend <= 1'b1;
            else if (rd_iid && iid == ID_THRE) thre_pend <= 1'b0;

            if (rx_done) begin
                rbr  <= rx_ch.data;
                dr_q <= 1'b1;
                oe_q <= oe_q | dr_q;
                pe_q <= pe_q | rx_ch.par_err;
                fe_q <= fe_q | rx_ch.frm_err;
            end else begin
                if (rd_data) dr_q <= 1'b0;
                if (rd_lsr) begin
                    oe_q <= 1'b0;
                    pe_q <= 1'b0;
                    fe_q <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/uart_loop_chk.sv
module uart_loop_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] reg_addr,
    input logic       reg_rd,
    input logic       ier_thre,
    input logic       thre_pend,
    input logic       thr_full,
    input logic       rx_done,
    input logic       dr_q,
    input logic       oe_q
);
    assert_thre_after_drain_R8: assert property (@(posedge clk) disable iff (rst)
        (ier_thre && thre_pend) |-> !thr_full);

    assert_overrun_R9: assert property (@(posedge clk) disable iff (rst)
        (rx_done && dr_q) |=> oe_q);

    assert_rbr_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 3'd0 && !rx_done) |=> !dr_q);

    assert_status_read_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 3'd5 && !rx_done) |=> !oe_q);

    assert_arrival_sets_ready_R5: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> dr_q);
endmodule

bind uart_loop uart_loop_chk u_chk (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .ier_thre(ier[1]), .thre_pend(thre_pend), .thr_full(thr_full),
    .rx_done(rx_done), .dr_q(dr_q), .oe_q(oe_q)
);

// File: tb/uart_loop_test.sv
module uart_loop_test;
    localparam int DIV = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic [2:0] reg_addr = '0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic serial_in = 1'b1;
    logic serial_out, irq;
    int vectors = 0, errors = 0;

    always #2 clk = ~clk;

    uart_loop #(.CLKS_PER_BIT(DIV)) uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .serial_in(serial_in),
        .serial_out(serial_out), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // waits for irq; returns 1 if the line ever left idle during the wait
    task automatic wait_irq(input string req, output logic line_moved);
        int n = 0;
        line_moved = 1'b0;
        while (!irq && n < 40 * DIV) begin
            @(negedge clk);
            if (!serial_out) line_moved = 1'b1;
            n++;
        end
        check({req, " irq arrives"}, {7'd0, irq}, 8'h01);
    endtask

    task automatic wait_tx_idle();
        logic [7:0] v;
        int n = 0;
        do begin rd(3'd5, v); n++; end while ((v & 8'h40) == 0 && n < 60 * DIV);
    endtask

    task automatic capture_frame(input string req, input logic [7:0] d, input logic even);
        int n = 0;
        while (serial_out && n < 10 * DIV) begin @(negedge clk); n++; end
        idle(DIV / 2);
        check({req, " start bit"}, {7'd0, serial_out}, 8'h00);
        for (int i = 0; i < 8; i++) begin
            idle(DIV);
            check({req, " data bit"}, {7'd0, serial_out}, {7'd0, d[i]});
        end
        idle(DIV);
        check({req, " parity bit"}, {7'd0, serial_out}, {7'd0, even ? ^d : ~^d});
        idle(DIV);
        check({req, " stop bit"}, {7'd0, serial_out}, 8'h01);
    endtask

    task automatic drive_frame(input logic [7:0] d, input logic par);
        @(negedge clk); serial_in = 1'b0; idle(DIV - 1);
        for (int i = 0; i < 8; i++) begin serial_in = d[i]; idle(DIV); end
        serial_in = par; idle(DIV);
        serial_in = 1'b1; idle(DIV);
    endtask

    task automatic t_reset();
        check("R1 serial_out", {7'd0, serial_out}, 8'h01);
        check("R1 irq", {7'd0, irq}, 8'h00);
        rd_check("R1 status", 3'd5, 8'h60);
        rd_check("R1 ident", 3'd2, 8'h01);
        rd_check("R1 enable", 3'd1, 8'h00);
    endtask

    task automatic t_regs();
        wr(3'd7, 8'h5C); rd_check("R2 scratch", 3'd7, 8'h5C);
        wr(3'd7, 8'hA3); rd_check("R2 scratch", 3'd7, 8'hA3);
        wr(3'd3, 8'h0B); rd_check("R2 line control", 3'd3, 8'h0B);
    endtask

    task automatic t_loopback();
        logic moved;
        wr(3'd4, 8'h10); rd_check("R2 mode control", 3'd4, 8'h10);
        wr(3'd1, 8'h01);
        wr(3'd0, 8'h68);
        wait_irq("R4 loop", moved);
        check("R4 serial_out idle in loop", {7'd0, moved}, 8'h00);
        idle(3 * DIV);
        rd_check("R7 ident data", 3'd2, 8'h04);
        rd_check("R5 status arrived", 3'd5, 8'h61);
        rd_check("R6 rbr", 3'd0, 8'h68);
        rd_check("R6 status after rbr", 3'd5, 8'h60);
        rd_check("R7 ident none", 3'd2, 8'h01);
    endtask

    task automatic t_line_out();
        wr(3'd4, 8'h00);
        wr(3'd0, 8'hA5);
        capture_frame("R3 odd", 8'hA5, 1'b0);
        wait_tx_idle();
        idle(4 * DIV);
        rd_check("R4 no reception", 3'd5, 8'h60);
        check("R4 no irq", {7'd0, irq}, 8'h00);
        wr(3'd3, 8'h1B);
        wr(3'd0, 8'h07);
        capture_frame("R3 even", 8'h07, 1'b1);
        wait_tx_idle();
        wr(3'd3, 8'h0B);
    endtask

    task automatic t_thre();
        logic moved;
        wr(3'd1, 8'h00);
        rd_check("R8 ident masked", 3'd2, 8'h01);
        wr(3'd1, 8'h02);
        check("R8 enable while empty", {7'd0, irq}, 8'h01);
        rd_check("R8 ident thre", 3'd2, 8'h02);
        rd_check("R8 ident cleared", 3'd2, 8'h01);
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h31);
        wr(3'd0, 8'h32);
        wr(3'd1, 8'h02);
        check("R8 no irq while holding full", {7'd0, irq}, 8'h00);
        rd_check("R8 status holding full", 3'd5, 8'h00);
        wait_irq("R8 drain", moved);
        rd_check("R8 status holding empty", 3'd5, 8'h20);
        wr(3'd0, 8'h33);
        check("R8 thr write clears", {7'd0, irq}, 8'h00);
        wr(3'd1, 8'h00);
        wait_tx_idle();
    endtask

    task automatic t_early_read();
        logic moved;
        logic [7:0] v;
        wr(3'd4, 8'h10);
        wr(3'd1, 8'h01);
        rd(3'd0, v);
        wr(3'd0, 8'h3C);
        rd(3'd0, v);
        check("R6 no irq before arrival", {7'd0, irq}, 8'h00);
        wait_irq("R6 early read", moved);
        idle(3 * DIV);
        rd_check("R6 ident after early read", 3'd2, 8'h04);
        rd_check("R6 rbr after early read", 3'd0, 8'h3C);
        rd_check("R6 ident none", 3'd2, 8'h01);
    endtask

    task automatic t_overrun();
        wr(3'd1, 8'h07);
        wr(3'd0, 8'h11);
        wr(3'd0, 8'h22);
        idle(40 * DIV);
        rd_check("R7 ident line first", 3'd2, 8'h06);
        rd_check("R9 status overrun", 3'd5, 8'h63);
        rd_check("R10 status cleared", 3'd5, 8'h61);
        rd_check("R7 ident data next", 3'd2, 8'h04);
        rd_check("R9 newest byte", 3'd0, 8'h22);
        rd_check("R7 ident thre last", 3'd2, 8'h02);
        rd_check("R7 ident none", 3'd2, 8'h01);
        check("R7 irq low", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_parity_err();
        wr(3'd4, 8'h00);
        wr(3'd1, 8'h04);
        drive_frame(8'h5A, 1'b0);
        idle(3 * DIV);
        check("R11 irq", {7'd0, irq}, 8'h01);
        rd_check("R11 ident line", 3'd2, 8'h06);
        rd_check("R11 status parity", 3'd5, 8'h65);
        rd_check("R11 rbr", 3'd0, 8'h5A);
        rd_check("R10 status clean", 3'd5, 8'h60);
        drive_frame(8'h5A, 1'b1);
        idle(3 * DIV);
        rd_check("R11 good parity", 3'd5, 8'h61);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        idle(4);
        rst = 1'b0;
        idle(2);
        t_reset();
        t_regs();
        t_loopback();
        t_line_out();
        t_thre();
        t_early_read();
        t_overrun();
        t_parity_err();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule